// File: doc/BRIEF.md
# Dual-Clock FIFO with Read-Side Replay

This block is a first-in first-out buffer whose two ports run on separate clocks. Port A writes 36-bit words on its own clock and port B reads them on a different one. A word moves only when that port's enable is high, its select is low, its direction input is high and its mailbox qualifier is low. The read port works in show-ahead fashion: the oldest unread word is always on `b_data` while `b_or` is high, and a read removes it.

Each side has its own flags, computed in its own clock domain from a synchronised copy of the other side's pointer. The reader sees output-ready and almost-empty. The writer sees input-ready and almost-full. Both thresholds are held in offset registers that load from ports. Pointers cross between the domains in gray code.

The read side can also replay data. Raising `b_rtm` marks the next word to be shown. While `b_rtm` stays high, each `b_rfm` pulse moves the read position back to that mark, as often as needed. The words from the mark onward stay reserved and the writer cannot reuse them. When `b_rtm` drops, the reserved locations go back to the writer.

Top module: `rtx_async_fifo`

## Requirements
- R1: A write happens on a rising `a_clk` edge only when `a_en`=1, `a_cs_n`=0, `a_dir`=1, `a_mbx`=0 and `a_ir`=1. Any other combination leaves the stored contents unchanged.
- R2: While `b_or`=1, `b_data` shows the oldest unread word. A read happens on a rising `b_clk` edge only when `b_en`=1, `b_cs_n`=0, `b_dir`=1, `b_mbx`=0 and `b_or`=1.
- R3: Reset (`rst_n`=0, asynchronous) empties the buffer and sets `a_ir`=1, `b_or`=0, `b_ae`=1 and `a_af`=0. It also loads the almost-empty offset with AE_DEF (2) and the almost-full offset with AF_DEF (2).
- R4: Words leave in the order they were written, and none is lost. `a_ir` is 0 while the writer counts DEPTH words as occupied, and writes tried in that state are dropped.
- R5: `b_ae`=1 when X or fewer words are stored and 0 when X+1 or more are stored. X is the almost-empty offset, which loads from `b_lvl_val` on a `b_clk` edge with `b_lvl_ld`=1.
- R6: `a_af`=1 when the writer counts DEPTH-Y or more occupied words and 0 when it counts DEPTH-Y-1 or fewer. Y is the almost-full offset, which loads from `a_lvl_val` on an `a_clk` edge with `a_lvl_ld`=1.
- R7: Sampling `b_rtm`=1 on a `b_clk` edge while replay mode is off turns replay mode on. The mark is set to the word shown on `b_data` after that edge.
- R8: In replay mode, sampling `b_rfm`=1 moves the read position back to the mark, and a read requested on that edge is not performed. This can repeat any number of times. Outside replay mode `b_rfm` has no effect.
- R9: In replay mode the writer counts every word from the mark onward as occupied, even if it has been read. `a_ir` therefore falls once DEPTH words lie at or past the mark.
- R10: Sampling `b_rtm`=0 in replay mode ends the mode. The words read past the mark are then freed, and `a_ir` returns to 1 once space exists.
- R11: When a rewind raises the stored count above X, `b_ae` is 0 by the second `b_clk` rising edge, counting the edge that samples `b_rfm`.
- R12: A written word becomes visible (`b_or`=1) no later than one `a_clk` edge plus three `b_clk` edges after its write edge. Pointers cross the clock domains in gray code, with at most one bit changing per source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Write-side clock |
| b_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_en | input | 1 | Write enable |
| a_cs_n | input | 1 | Write-port select, active low |
| a_dir | input | 1 | Write-port direction, must be 1 to write |
| a_mbx | input | 1 | Write-port mailbox qualifier, must be 0 to write |
| a_data | input | WIDTH | Word to write |
| a_lvl_ld | input | 1 | Load strobe for the almost-full offset |
| a_lvl_val | input | log2(DEPTH) | New almost-full offset |
| a_ir | output | 1 | Input ready, space available |
| a_af | output | 1 | Almost full |
| b_en | input | 1 | Read enable |
| b_cs_n | input | 1 | Read-port select, active low |
| b_dir | input | 1 | Read-port direction, must be 1 to read |
| b_mbx | input | 1 | Read-port mailbox qualifier, must be 0 to read |
| b_rtm | input | 1 | Replay mode request (level) |
| b_rfm | input | 1 | Rewind to mark |
| b_lvl_ld | input | 1 | Load strobe for the almost-empty offset |
| b_lvl_val | input | log2(DEPTH) | New almost-empty offset |
| b_data | output | WIDTH | Oldest unread word (show-ahead) |
| b_or | output | 1 | Output ready, a word is available |
| b_ae | output | 1 | Almost empty |

## Verification
The bench uses the defaults DEPTH=16, WIDTH=36, AE_DEF=2 and AF_DEF=2. At this depth, a few dozen writes reach full, fill the reserved region during replay and land on each offset boundary, both with the reset values and with loaded ones. Write and read clocks of different periods make the pointer crossings drift in phase during the random phase. In that phase, enables are randomly qualified and replay mode is entered, rewound and left at random points.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

  typedef enum logic {RT_OFF = 1'b0, RT_ON = 1'b1} rt_state_e;

  // threshold compare used by the almost-empty flag
  function automatic logic lvl_at_most(logic [31:0] cnt, logic [31:0] lim);
    return cnt <= lim;
  endfunction

  // threshold compare used by the almost-full flag
  function automatic logic lvl_at_least(logic [31:0] cnt, logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/rtx_ptr_xing.sv
module rtx_ptr_xing #(
  parameter int PW = 5
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);

  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] src_gray, meta_q, sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) src_gray <= '0;
    else        src_gray <= to_gray(src_bin);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  assign dst_bin = from_gray(sync_q);

  // R12
  gray_step_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $countones(src_gray ^ $past(src_gray)) <= 1);

endmodule

// File: rtl/rtx_mem.sv
module rtx_mem #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/rtx_wr_side.sv
module rtx_wr_side
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AF_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_n,
  input  logic          dir,
  input  logic          mbx,
  input  logic          lvl_ld,
  input  logic [AW-1:0] lvl_val,
  input  logic [PW-1:0] rel_bin,
  output logic          ir,
  output logic          af,
  output logic          we,
  output logic [PW-1:0] wptr
);

  logic [AW-1:0] af_ofs;
  logic [PW-1:0] used;
  logic          qual;
  logic          wr_go;

  assign used  = wptr - rel_bin;
  assign ir    = (used != PW'(DEPTH));
  assign qual  = en & ~cs_n & dir & ~mbx;
  assign wr_go = qual & ir;
  assign we    = wr_go;
  assign af    = lvl_at_least(32'(used), 32'(DEPTH) - 32'(af_ofs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      af_ofs <= AW'(AF_DEF);
    end else begin
      wptr <= wptr + {{(PW-1){1'b0}}, wr_go};
      if (lvl_ld) af_ofs <= lvl_val;
    end
  end

  // R1
  wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> wptr == $past(wptr));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rel_bin) <= PW'(DEPTH));

endmodule

// File: rtl/rtx_rd_side.sv
module rtx_rd_side
  import rtx_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_n,
  input  logic          dir,
  input  logic          mbx,
  input  logic          rtm,
  input  logic          rfm,
  input  logic          lvl_ld,
  input  logic [AW-1:0] lvl_val,
  input  logic [PW-1:0] wr_bin,
  output logic          ordy,
  output logic          ae,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rel_ptr
);

  rt_state_e     mode;
  logic [PW-1:0] rptr, rptr_nx, mark, rel_tgt, stored;
  logic [AW-1:0] ae_ofs;
  logic          rt_on, rewind, rd_go, rel_step;

  assign rt_on    = (mode == RT_ON);
  assign stored   = wr_bin - rptr;
  assign ordy     = (stored != '0);
  assign rewind   = rt_on & rfm;
  assign rd_go    = en & ~cs_n & dir & ~mbx & ordy & ~rewind;
  assign rptr_nx  = rewind ? mark : rptr + {{(PW-1){1'b0}}, rd_go};
  assign raddr    = rptr[AW-1:0];
  assign ae       = lvl_at_most(32'(stored), 32'(ae_ofs));
  assign rel_tgt  = rt_on ? mark : rptr;
  assign rel_step = (rel_ptr != rel_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= RT_OFF;
      rptr    <= '0;
      mark    <= '0;
      rel_ptr <= '0;
      ae_ofs  <= AW'(AE_DEF);
    end else begin
      rptr    <= rptr_nx;
      rel_ptr <= rel_ptr + {{(PW-1){1'b0}}, rel_step};
      if (lvl_ld) ae_ofs <= lvl_val;
      if (!rt_on && rtm) begin
        mode <= RT_ON;
        mark <= rptr_nx;
      end else if (rt_on && !rtm) begin
        mode <= RT_OFF;
      end
    end
  end

  // R2
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bin - rptr) <= PW'(DEPTH));

  // R7
  mark_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_on) |-> mark == rptr);

  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_on && rfm |=> rptr == $past(mark));

  // R8
  rfm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_on && rfm && !en |=> rptr == $past(rptr));

  // R9
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_on && rtm |=> $stable(mark));

  // R10
  rel_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ptr - $past(rel_ptr)) <= PW'(1));

endmodule

// File: rtl/rtx_async_fifo.sv
module rtx_async_fifo #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 36,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             a_clk,
  input  logic             b_clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic             a_cs_n,
  input  logic             a_dir,
  input  logic             a_mbx,
  input  logic [WIDTH-1:0] a_data,
  input  logic             a_lvl_ld,
  input  logic [AW-1:0]    a_lvl_val,
  output logic             a_ir,
  output logic             a_af,
  input  logic             b_en,
  input  logic             b_cs_n,
  input  logic             b_dir,
  input  logic             b_mbx,
  input  logic             b_rtm,
  input  logic             b_rfm,
  input  logic             b_lvl_ld,
  input  logic [AW-1:0]    b_lvl_val,
  output logic [WIDTH-1:0] b_data,
  output logic             b_or,
  output logic             b_ae
);

  logic [PW-1:0] wptr, wptr_at_b, rel_ptr, rel_at_a;
  logic [AW-1:0] raddr;
  logic          we;

  rtx_wr_side #(.DEPTH(DEPTH), .AF_DEF(AF_DEF)) u_wr (
    .clk(a_clk), .rst_n(rst_n), .en(a_en), .cs_n(a_cs_n), .dir(a_dir),
    .mbx(a_mbx), .lvl_ld(a_lvl_ld), .lvl_val(a_lvl_val), .rel_bin(rel_at_a),
    .ir(a_ir), .af(a_af), .we(we), .wptr(wptr)
  );

  rtx_rd_side #(.DEPTH(DEPTH), .AE_DEF(AE_DEF)) u_rd (
    .clk(b_clk), .rst_n(rst_n), .en(b_en), .cs_n(b_cs_n), .dir(b_dir),
    .mbx(b_mbx), .rtm(b_rtm), .rfm(b_rfm), .lvl_ld(b_lvl_ld),
    .lvl_val(b_lvl_val), .wr_bin(wptr_at_b), .ordy(b_or), .ae(b_ae),
    .raddr(raddr), .rel_ptr(rel_ptr)
  );

  rtx_ptr_xing #(.PW(PW)) u_w2r (
    .src_clk(a_clk), .dst_clk(b_clk), .rst_n(rst_n),
    .src_bin(wptr), .dst_bin(wptr_at_b)
  );

  rtx_ptr_xing #(.PW(PW)) u_r2w (
    .src_clk(b_clk), .dst_clk(a_clk), .rst_n(rst_n),
    .src_bin(rel_ptr), .dst_bin(rel_at_a)
  );

  rtx_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wclk(a_clk), .we(we), .waddr(wptr[AW-1:0]), .wdata(a_data),
    .raddr(raddr), .rdata(b_data)
  );

endmodule

// File: tb/rtx_async_fifo_bench.sv
`timescale 1ns/1ps
module rtx_async_fifo_bench;

  localparam int DEPTH = 16;
  localparam int WIDTH = 36;
  localparam int AW    = 4;

  logic             a_clk = 0, b_clk = 0, rst_n = 0;
  logic             a_en = 0, a_cs_n = 1, a_dir = 0, a_mbx = 0;
  logic [WIDTH-1:0] a_data = '0;
  logic             a_lvl_ld = 0;
  logic [AW-1:0]    a_lvl_val = '0;
  logic             a_ir, a_af;
  logic             b_en = 0, b_cs_n = 1, b_dir = 0, b_mbx = 0;
  logic             b_rtm = 0, b_rfm = 0, b_lvl_ld = 0;
  logic [AW-1:0]    b_lvl_val = '0;
  logic [WIDTH-1:0] b_data;
  logic             b_or, b_ae;

  always #2.5 a_clk = ~a_clk;
  always #3.5 b_clk = ~b_clk;

  rtx_async_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rtx_async_fifo (.*);

  int n_cmp = 0, n_bad = 0;
  logic [WIDTH-1:0] mdl [2048];
  int wr_n = 0, rd_n = 0, mark_n = 0;
  bit in_mode = 0;
  int x_lvl = 2, y_lvl = 2;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected flag values computed from the requirements
  function automatic bit exp_ae(int stored, int x);
    return stored <= x;
  endfunction
  function automatic bit exp_af(int used, int y);
    return used >= DEPTH - y;
  endfunction

  // mode 0 qualified; 1 select high; 2 direction low; 3 mailbox high; 4 enable low
  task automatic wr_word(input logic [WIDTH-1:0] d, input int mode, output bit took);
    @(negedge a_clk);
    a_en = (mode != 4); a_cs_n = (mode == 1); a_dir = (mode != 2); a_mbx = (mode == 3);
    a_data = d;
    took = (mode == 0) && a_ir;
    if (took) begin
      mdl[wr_n % 2048] = d;
      wr_n++;
    end
    @(posedge a_clk); #1;
    a_en = 0; a_cs_n = 1;
  endtask

  task automatic wr_n_words(input int n);
    bit t;
    for (int i = 0; i < n; i++) wr_word(WIDTH'({$urandom, $urandom}), 0, t);
  endtask

  task automatic rd_step(input bit req, input bit rtm, input bit rfm, input int mode,
                         input string tag);
    bit rew;
    @(negedge b_clk);
    b_en = req && (mode != 4); b_cs_n = (mode == 1); b_dir = (mode != 2);
    b_mbx = (mode == 3); b_rtm = rtm; b_rfm = rfm;
    rew = in_mode && rfm;
    if (rew) rd_n = mark_n;
    else if (req && mode == 0 && b_or) begin
      chk(tag, b_data, mdl[rd_n % 2048]);
      rd_n++;
    end
    if (!in_mode && rtm) begin
      in_mode = 1;
      mark_n = rd_n;
    end else if (in_mode && !rtm) in_mode = 0;
    @(posedge b_clk); #1;
    b_en = 0; b_rfm = 0;
  endtask

  task automatic settle();
    repeat (40) @(posedge b_clk);
    repeat (4) @(posedge a_clk);
  endtask

  task automatic chk_flags(input string tag);
    int used;
    settle();
    @(negedge b_clk);
    chk({tag, " b_or"}, b_or, (wr_n != rd_n));
    chk({tag, " b_ae"}, b_ae, exp_ae(wr_n - rd_n, x_lvl));
    used = wr_n - (in_mode ? mark_n : rd_n);
    @(negedge a_clk);
    chk({tag, " a_ir"}, a_ir, (used < DEPTH));
    chk({tag, " a_af"}, a_af, exp_af(used, y_lvl));
  endtask

  initial begin
    #1000000ns;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit t;
    int acc;
    void'($urandom(32'd4711));
    repeat (4) @(posedge a_clk);
    @(negedge a_clk); rst_n = 1;
    @(negedge b_clk);
    // R3 reset state
    chk("R3 a_ir", a_ir, 1); chk("R3 b_or", b_or, 0);
    chk("R3 b_ae", b_ae, 1); chk("R3 a_af", a_af, 0);

    // R12 visibility latency
    wr_word(36'h123456789, 0, t);
    @(posedge a_clk); repeat (3) @(posedge b_clk); @(negedge b_clk);
    chk("R12 b_or", b_or, 1);
    rd_step(1, 0, 0, 0, "R2 data");
    chk_flags("R2");

    // R3 R5 default almost-empty offset boundary
    wr_n_words(2); chk_flags("R3 R5");
    wr_n_words(1); chk_flags("R3 R5");
    // R3 R6 default almost-full offset boundary
    wr_n_words(10); chk_flags("R3 R6");
    wr_n_words(1); chk_flags("R3 R6");
    // R4 fill and overflow attempt
    wr_n_words(2); chk_flags("R4");
    wr_word(36'hDEADBEEF, 0, t);
    chk("R4 dropped", t, 0);
    for (int i = 0; i < DEPTH; i++) rd_step(1, 0, 0, 0, "R4 order");
    chk_flags("R4");

    // R1 unqualified writes
    for (int m = 1; m <= 4; m++) wr_word(36'hBAD, m, t);
    chk_flags("R1");
    wr_n_words(1);
    // R2 unqualified reads
    for (int m = 1; m <= 4; m++) rd_step(1, 0, 0, m, "R2 data");
    chk_flags("R2");
    rd_step(1, 0, 0, 0, "R2 data");

    // R5 R6 loaded offsets
    @(negedge a_clk); a_lvl_ld = 1; a_lvl_val = 4'd4;
    @(posedge a_clk); #1 a_lvl_ld = 0; y_lvl = 4;
    @(negedge b_clk); b_lvl_ld = 1; b_lvl_val = 4'd5;
    @(posedge b_clk); #1 b_lvl_ld = 0; x_lvl = 5;
    wr_n_words(5); chk_flags("R5");
    wr_n_words(1); chk_flags("R5");
    wr_n_words(5); chk_flags("R6");
    wr_n_words(1); chk_flags("R6");
    for (int i = 0; i < 12; i++) rd_step(1, 0, 0, 0, "R6 data");

    // R8 rewind request outside replay mode is ignored
    wr_n_words(3); settle();
    rd_step(1, 0, 1, 0, "R8 idle rfm");
    rd_step(1, 0, 1, 0, "R8 idle rfm");
    rd_step(1, 0, 0, 0, "R8 idle rfm");
    chk_flags("R8");

    // R7 R8 R9 R10 replay sequence
    wr_n_words(6); settle();
    rd_step(0, 1, 0, 0, "R7");
    for (int i = 0; i < 3; i++) rd_step(1, 1, 0, 0, "R7 data");
    rd_step(0, 1, 1, 0, "R8");
    for (int i = 0; i < 6; i++) rd_step(1, 1, 0, 0, "R8 replay");
    settle();
    acc = 0;
    for (int i = 0; i < 12; i++) begin
      wr_word(WIDTH'({$urandom, $urandom}), 0, t);
      acc += int'(t);
    end
    chk("R9 accepted", acc, DEPTH - 6);
    chk_flags("R9");
    rd_step(0, 1, 1, 0, "R8");
    for (int i = 0; i < DEPTH; i++) rd_step(1, 1, 0, 0, "R8 replay2");
    chk_flags("R9");
    rd_step(0, 0, 0, 0, "R10");
    chk_flags("R10");

    // R11 almost-empty clears quickly after a rewind
    wr_n_words(7); settle();
    rd_step(0, 1, 0, 0, "R11");
    for (int i = 0; i < 4; i++) rd_step(1, 1, 0, 0, "R11 data");
    settle(); @(negedge b_clk);
    chk("R11 ae before", b_ae, 1);
    rd_step(0, 1, 1, 0, "R11");
    @(posedge b_clk); @(negedge b_clk);
    chk("R11 ae after", b_ae, 0);
    rd_step(0, 0, 0, 0, "R11");
    for (int i = 0; i < 7; i++) rd_step(1, 0, 0, 0, "R11 data");
    chk_flags("R11");

    // random phase: R1 R2 R4 R7 R8 data ordering
    fork
      begin
        for (int i = 0; i < 500; i++) begin
          bit tk;
          wr_word(WIDTH'({$urandom, $urandom}), ($urandom % 5 == 0) ? int'($urandom % 4) + 1 : 0, tk);
          if ($urandom % 3 == 0) @(posedge a_clk);
        end
      end
      begin
        bit rt = 0;
        for (int i = 0; i < 900; i++) begin
          if ($urandom % 25 == 0) rt = ~rt;
          rd_step(($urandom % 10) < 7, rt, rt && ($urandom % 12 == 0),
                  ($urandom % 6 == 0) ? int'($urandom % 4) + 1 : 0, "R4 random");
        end
        rd_step(0, 0, 0, 0, "R10");
      end
    join
    for (int i = 0; i < 200 && rd_n != wr_n; i++) rd_step(1, 0, 0, 0, "R4 drain");
    chk_flags("R4 final");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule